// File: doc/BRIEF.md
# Quarter-Duty LCD Waveform Sequencer

This block chooses the drive level for every line of a multiplexed liquid-crystal panel that has four common lines and thirty-two segment lines and is driven at one-third bias. Each output is a 2-bit code. The code tells an external analog switch which of four supply rails to connect to that line. The block itself makes no voltages.

A timing-tick enable advances a common counter through the four commons in turn. The frame polarity flips each time the counter wraps. This flip keeps the average voltage on the glass at zero.

The display memory is supplied as a flat vector with one word per segment. The bit chosen by the active common decides whether that segment is lit in the current time slot. A registered display-enable takes effect one clock after its input changes. While the display is disabled, every line sits at its deselected level for the current polarity.

Top module: `lcd_quarter_seq`

## Requirements
- R1: After reset the active common index is 0, the polarity is positive (`frame_neg`=0) and the display is disabled. Every common then reads code 2 and every segment reads code 1.
- R2: The active common index advances by one on each clock edge where `tick_en` is high, in the order 0,1,2,3,0. It holds on every edge where `tick_en` is low.
- R3: The polarity inverts on exactly those ticks that wrap the index from 3 back to 0. It is unchanged on all other clock edges.
- R4: In positive polarity with the display enabled, the active common reads code 0 (VDD) and every other common reads code 2 (V2). Level codes are: 0=VDD, 1=V1, 2=V2, 3=V3.
- R5: In negative polarity with the display enabled, the active common reads code 3 (V3) and every other common reads code 1 (V1).
- R6: In positive polarity, a lit segment reads code 3 (V3) and an unlit segment reads code 1 (V1).
- R7: In negative polarity, a lit segment reads code 0 (VDD) and an unlit segment reads code 2 (V2).
- R8: Segment n is lit when the display is enabled and bit `4*n+k` of `seg_data` is 1, where k is the active common index. Segment n's code sits at bits `2*n+1:2*n` of `seg_lvl`. Common c's code sits at bits `2*c+1:2*c` of `com_lvl`.
- R9: `disp_on` is registered. One clock after it falls, all commons and segments show their deselected levels for the current polarity. The common counter and the polarity keep running while the display is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_en | input | 1 | Display timing tick, one step of the common counter |
| disp_on | input | 1 | Display enable request, registered |
| seg_data | input | 128 | Display memory, 4 bits per segment word |
| com_lvl | output | 8 | Level code per common line |
| seg_lvl | output | 64 | Level code per segment line |
| com_idx | output | 2 | Active common index |
| frame_neg | output | 1 | Frame polarity, 1 = negative |

## Verification
The bench builds the block with its default values of four commons and thirty-two segments. These values match the real panel. The 2-bit index therefore wraps naturally, and every segment's four-bit word can be reached from the bench. Two full frames reach both polarities on every common. Walking-bit and per-segment distinct memory patterns expose any wrong bit selection. Turning the display off during a negative frame covers the deselected levels of that polarity.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  typedef enum logic [1:0] {
    LVL_VDD = 2'd0,
    LVL_V1  = 2'd1,
    LVL_V2  = 2'd2,
    LVL_V3  = 2'd3
  } lvl_e;
endpackage

// File: rtl/lcd_com_counter.sv
module lcd_com_counter #(
  parameter int NUM_COM = 4,
  localparam int IDX_W  = $clog2(NUM_COM)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  output logic [IDX_W-1:0] idx_q,
  output logic             neg_q
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_COM - 1);

  logic [IDX_W-1:0] idx_d;
  logic             neg_d;

  always_comb begin
    idx_d = idx_q;
    neg_d = neg_q;
    if (tick_en) begin
      if (idx_q == LAST) begin
        idx_d = '0;
        neg_d = ~neg_q;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      neg_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      neg_q <= neg_d;
    end
  end
endmodule

// File: rtl/lcd_com_drv.sv
module lcd_com_drv
  import lcd_seq_pkg::*;
#(
  parameter int NUM_COM = 4,
  localparam int IDX_W  = $clog2(NUM_COM)
) (
  input  logic [IDX_W-1:0]     idx,
  input  logic                 neg,
  input  logic                 on,
  output logic [2*NUM_COM-1:0] lvl
);
  lvl_e sel_lvl, desel_lvl;

  assign sel_lvl   = neg ? LVL_V3 : LVL_VDD;
  assign desel_lvl = neg ? LVL_V1 : LVL_V2;

  for (genvar c = 0; c < NUM_COM; c++) begin : g_com
    assign lvl[2*c +: 2] = (on && idx == IDX_W'(c)) ? sel_lvl : desel_lvl;
  end
endmodule

// File: rtl/lcd_seg_drv.sv
module lcd_seg_drv
  import lcd_seq_pkg::*;
#(
  parameter int NUM_COM = 4,
  parameter int NUM_SEG = 32,
  localparam int IDX_W  = $clog2(NUM_COM)
) (
  input  logic [IDX_W-1:0]         idx,
  input  logic                     neg,
  input  logic                     on,
  input  logic [NUM_COM*NUM_SEG-1:0] data,
  output logic [2*NUM_SEG-1:0]     lvl
);
  lvl_e lit_lvl, dark_lvl;

  assign lit_lvl  = neg ? LVL_VDD : LVL_V3;
  assign dark_lvl = neg ? LVL_V2  : LVL_V1;

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    logic [NUM_COM-1:0] word;
    logic               lit;
    assign word = data[NUM_COM*s +: NUM_COM];
    assign lit  = on & word[idx];
    assign lvl[2*s +: 2] = lit ? lit_lvl : dark_lvl;
  end
endmodule

// File: rtl/lcd_quarter_seq.sv
module lcd_quarter_seq #(
  parameter int NUM_COM = 4,
  parameter int NUM_SEG = 32,
  localparam int IDX_W  = $clog2(NUM_COM),
  localparam int RAM_W  = NUM_COM * NUM_SEG
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_en,
  input  logic               disp_on,
  input  logic [RAM_W-1:0]   seg_data,
  output logic [2*NUM_COM-1:0] com_lvl,
  output logic [2*NUM_SEG-1:0] seg_lvl,
  output logic [IDX_W-1:0]   com_idx,
  output logic               frame_neg
);
  logic disp_q, disp_d;

  assign disp_d = disp_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) disp_q <= 1'b0;
    else        disp_q <= disp_d;
  end

  lcd_com_counter #(.NUM_COM(NUM_COM)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .idx_q   (com_idx),
    .neg_q   (frame_neg)
  );

  lcd_com_drv #(.NUM_COM(NUM_COM)) u_com (
    .idx (com_idx),
    .neg (frame_neg),
    .on  (disp_q),
    .lvl (com_lvl)
  );

  lcd_seg_drv #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG)) u_seg (
    .idx  (com_idx),
    .neg  (frame_neg),
    .on   (disp_q),
    .data (seg_data),
    .lvl  (seg_lvl)
  );
endmodule

// File: rtl/lcd_quarter_seq_chk.sv
module lcd_quarter_seq_chk #(
  parameter int NUM_COM = 4,
  localparam int IDX_W  = $clog2(NUM_COM)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick_en,
  input logic               disp_q,
  input logic [IDX_W-1:0]   com_idx,
  input logic               frame_neg,
  input logic [2*NUM_COM-1:0] com_lvl
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_COM - 1);

  int unsigned sel_cnt;
  logic [1:0]  sel_code;

  assign sel_code = frame_neg ? 2'd3 : 2'd0;

  always_comb begin
    sel_cnt = 0;
    for (int c = 0; c < NUM_COM; c++)
      if (com_lvl[2*c +: 2] == sel_code) sel_cnt++;
  end

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(com_idx));

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && com_idx != LAST) |=> com_idx == $past(com_idx) + 1'b1);

  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && com_idx == LAST) |=> com_idx == '0);

  a_r3_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && com_idx == LAST) |=> frame_neg != $past(frame_neg));

  a_r3_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick_en && com_idx == LAST) |=> $stable(frame_neg));

  a_r4_one_sel: assert property (@(posedge clk) disable iff (!rst_n)
    disp_q |-> sel_cnt == 1);

  a_r9_none_sel: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_q |-> sel_cnt == 0);
endmodule

bind lcd_quarter_seq lcd_quarter_seq_chk #(.NUM_COM(NUM_COM)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .disp_q    (disp_q),
  .com_idx   (com_idx),
  .frame_neg (frame_neg),
  .com_lvl   (com_lvl)
);

// File: tb/tb_lcd_quarter_seq.sv
module tb_lcd_quarter_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int NS = 32;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             tick_en;
  logic             disp_on;
  logic [NC*NS-1:0] seg_data;
  logic [2*NC-1:0]  com_lvl;
  logic [2*NS-1:0]  seg_lvl;
  logic [1:0]       com_idx;
  logic             frame_neg;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  int m_idx;
  bit m_neg;
  bit m_on;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_quarter_seq #(.NUM_COM(NC), .NUM_SEG(NS)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .disp_on(disp_on),
    .seg_data(seg_data), .com_lvl(com_lvl), .seg_lvl(seg_lvl),
    .com_idx(com_idx), .frame_neg(frame_neg)
  );

  function automatic logic [2*NC-1:0] exp_com(int k, bit neg, bit on);
    logic [2*NC-1:0] v;
    for (int c = 0; c < NC; c++)
      v[2*c +: 2] = (on && c == k) ? (neg ? 2'd3 : 2'd0) : (neg ? 2'd1 : 2'd2);
    return v;
  endfunction

  function automatic logic [2*NS-1:0] exp_seg(int k, bit neg, bit on,
                                               logic [NC*NS-1:0] d);
    logic [2*NS-1:0] v;
    for (int s = 0; s < NS; s++) begin
      bit lit = on && d[NC*s + k];
      v[2*s +: 2] = lit ? (neg ? 2'd0 : 2'd3) : (neg ? 2'd2 : 2'd1);
    end
    return v;
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_state(string req);
    check({req, " com_idx"},   128'(com_idx),   128'(m_idx));
    check({req, " frame_neg"}, 128'(frame_neg), 128'(m_neg));
    check({req, " com_lvl"},   128'(com_lvl),   128'(exp_com(m_idx, m_neg, m_on)));
    check({req, " seg_lvl"},   128'(seg_lvl),   128'(exp_seg(m_idx, m_neg, m_on, seg_data)));
  endtask

  // one tick per cycle for n cycles, checking after each edge
  task automatic run_ticks(int n, string req);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1;
      @(negedge clk);
      if (m_idx == NC - 1) begin m_idx = 0; m_neg = ~m_neg; end
      else m_idx++;
      check_state(req);
    end
    tick_en = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; tick_en = 1'b0; disp_on = 1'b0; seg_data = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    m_idx = 0; m_neg = 0; m_on = 0;
    check_state("R1 reset");
    check("R1 coms", 128'(com_lvl), 128'({NC{2'd2}}));
    check("R1 segs", 128'(seg_lvl), 128'({NS{2'd1}}));
  endtask

  task automatic t_enable;
    disp_on = 1'b1;
    #1;
    check("R9 enable registered", 128'(seg_lvl), 128'({NS{2'd1}}));
    @(negedge clk);
    m_on = 1;
    check_state("R4 R6 enabled");
  endtask

  task automatic t_hold;
    tick_en = 1'b0;
    repeat (5) @(negedge clk);
    check_state("R2 hold without tick");
  endtask

  task automatic t_walk;
    for (int s = 0; s < NS; s++) seg_data[NC*s +: NC] = 4'(s * 5 + 3);
    #1;
    check_state("R8 distinct words");
    run_ticks(8, "R2 R3 R4 R5 R6 R7 R8 walk");
  endtask

  task automatic t_walking_bit;
    for (int s = 0; s < NS; s++) seg_data[NC*s +: NC] = 4'(1 << (s % NC));
    #1;
    check_state("R8 walking bit");
    run_ticks(4, "R8 walking bit");
    run_ticks(3, "R3 R5 R7 into negative frame");
    check("R3 negative", 128'(frame_neg), 128'(1));
  endtask

  task automatic t_off;
    seg_data = '1;
    disp_on = 1'b0;
    @(negedge clk);
    m_on = 0;
    check_state("R9 off negative");
    check("R9 com desel neg", 128'(com_lvl), 128'({NC{2'd1}}));
    check("R9 seg desel neg", 128'(seg_lvl), 128'({NS{2'd2}}));
    run_ticks(2, "R9 counter runs while off");
    check("R9 seg desel pos", 128'(seg_lvl), 128'({NS{2'd1}}));
    disp_on = 1'b1;
    @(negedge clk);
    m_on = 1;
    check_state("R6 R9 back on");
  endtask

  initial begin
    t_reset();
    t_enable();
    t_hold();
    t_walk();
    t_walking_bit();
    t_off();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule